// File: doc/BRIEF.md
# Reference-Disciplined Oscillator Trim Controller

This block keeps a local sample clock on frequency by comparing it against an external reference clock. A divider running on the reference clock flips a gate signal every `ref_div` reference cycles. The gate is carried into the local clock domain, and the block counts local ticks between successive gate edges. That count is subtracted from a programmed expected count to give a signed error. The error, scaled down by a programmable right shift, is added to a 16-bit tuning word for the oscillator's DAC. The word is kept within the DAC's range, and each new word comes with a one-cycle write strobe.

A lock flag reports that the loop has settled, and a reference-loss flag reports that gate edges have stopped arriving. While reference loss is flagged, the DAC word is held. With the nominal settings (a 10 MHz reference divided by 10,000,000 and a 38.4 MHz local clock), the expected count is 38,400,000 per one-second gate. The driver that moves the code into the DAC, and any analog conditioning of the reference, sit outside this block.

Top module: `osc_trim_ctrl`

## Requirements
- R1: While reset is applied and after it is released, `dac_code` reads 32768, `error_out` reads 0, and `dac_write`, `locked` and `ref_lost` read 0.
- R2: One gate interval lasts `ref_div` reference cycles. The measured count is the number of local cycles between two consecutive synchronized gate edges. `error_out` is `expected` minus the measured count as a signed 32-bit value, and it is updated together with the strobe.
- R3: The first gate edge after reset, after `enable` rises, or after reference loss only starts a measurement. It produces no strobe and no change to `dac_code`.
- R4: Each used measurement sets `dac_code` to its old value plus `error_out` arithmetically shifted right by `gain_shift` bits. The shift rounds toward minus infinity, so an error of -7 with a shift of 1 gives a step of -4.
- R5: The new code is clamped to the range 0 to 65535.
- R6: `dac_write` is high for exactly one local cycle per used measurement. `dac_code` changes only in a cycle in which `dac_write` is high.
- R7: `locked` rises at the strobe of the `lock_len`-th consecutive used measurement whose error magnitude is at or below `tolerance`.
- R8: `locked` falls at the strobe of the first used measurement whose error magnitude exceeds `tolerance`.
- R9: `ref_lost` rises, and `locked` falls, once more than twice `expected` local cycles pass without a gate edge.
- R10: While `ref_lost` is high, no strobe occurs and `dac_code` holds. The next gate edge clears `ref_lost`.
- R11: While `enable` is low, no strobe occurs, `dac_code` holds, and `locked` and `ref_lost` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | External reference clock |
| clk_loc | input | 1 | Local clock being disciplined |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| enable | input | 1 | Runs the loop when high (local domain) |
| ref_div | input | 32 | Reference cycles per gate interval |
| expected | input | 32 | Local ticks expected per gate interval |
| gain_shift | input | 5 | Right shift applied to the error before it is added |
| tolerance | input | 32 | Largest error magnitude counted as in-lock |
| lock_len | input | 8 | In-tolerance intervals in a row needed for lock |
| dac_code | output | 16 | Tuning word for the oscillator DAC |
| dac_write | output | 1 | One-cycle strobe for a new tuning word |
| error_out | output | 32 | Signed error of the last used measurement |
| locked | output | 1 | Loop is within tolerance |
| ref_lost | output | 1 | Gate edges have stopped arriving |

## Verification
The hardest state to reach is the lower clamp. The loss detector allows a measured count of at most twice `expected`, so a single interval can pull the code down by only about half its own length. The bench therefore lengthens the gate to 33,000 local cycles with an expected count of 16,600. From the reset code this takes two used intervals: the first moves the code to 16368, and the second drives it below zero, where it is clamped to 0. Reference loss is produced by stopping the bench's reference clock while the local clock keeps running. After that, the bench checks that the code stays frozen, that the first edge after the reference restarts is discarded, and that the following edge updates the code normally.

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl #(
  parameter int DIV_W = 32,
  parameter int CNT_W = 32,
  parameter int DAC_W = 16,
  parameter int SHIFT_W = 5,
  parameter int RUN_W = 8,
  parameter logic [DAC_W-1:0] DAC_RESET = {1'b1, {(DAC_W-1){1'b0}}}
) (
  input  logic                    clk_ref,
  input  logic                    clk_loc,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [DIV_W-1:0]        ref_div,
  input  logic [CNT_W-1:0]        expected,
  input  logic [SHIFT_W-1:0]      gain_shift,
  input  logic [CNT_W-1:0]        tolerance,
  input  logic [RUN_W-1:0]        lock_len,
  output logic [DAC_W-1:0]        dac_code,
  output logic                    dac_write,
  output logic signed [CNT_W-1:0] error_out,
  output logic                    locked,
  output logic                    ref_lost
);
  localparam int TW = CNT_W + 1;
  localparam int SW = CNT_W + 2;
  localparam logic signed [SW-1:0] DAC_MAX = $signed({{(SW-DAC_W){1'b0}}, {DAC_W{1'b1}}});

  logic [DIV_W-1:0] div_cnt;
  logic             gate_tgl;
  logic             div_wrap;

  assign div_wrap = ({1'b0, div_cnt} + 1'b1) >= {1'b0, ref_div};

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      gate_tgl <= 1'b0;
    end else if (div_wrap) begin
      div_cnt  <= '0;
      gate_tgl <= ~gate_tgl;
    end else begin
      div_cnt  <= div_cnt + 1'b1;
    end
  end

  logic [2:0]              tgl_sync;
  logic                    gate_evt;
  logic [TW-1:0]           ticks;
  logic                    armed;
  logic [RUN_W-1:0]        run;
  logic signed [CNT_W-1:0] err;
  logic signed [CNT_W-1:0] step;
  logic signed [SW-1:0]    sum;
  logic [DAC_W-1:0]        next_code;
  logic [CNT_W-1:0]        err_mag;
  logic                    in_tol;
  logic                    lost_now;
  logic [RUN_W:0]          run_next;

  always_ff @(posedge clk_loc or negedge rst_n) begin
    if (!rst_n) tgl_sync <= '0;
    else        tgl_sync <= {tgl_sync[1:0], gate_tgl};
  end

  assign gate_evt = tgl_sync[2] ^ tgl_sync[1];
  assign err      = $signed(expected - ticks[CNT_W-1:0]);
  assign step     = err >>> gain_shift;
  assign sum      = $signed({{(SW-DAC_W){1'b0}}, dac_code}) + $signed({{2{step[CNT_W-1]}}, step});
  assign err_mag  = err[CNT_W-1] ? $unsigned(-err) : $unsigned(err);
  assign in_tol   = err_mag <= tolerance;
  assign lost_now = ticks > {expected, 1'b0};
  assign run_next = {1'b0, run} + 1'b1;

  always_comb begin
    if (sum < 0)             next_code = '0;
    else if (sum > DAC_MAX)  next_code = '1;
    else                     next_code = sum[DAC_W-1:0];
  end

  always_ff @(posedge clk_loc or negedge rst_n) begin
    if (!rst_n) begin
      ticks     <= '0;
      armed     <= 1'b0;
      run       <= '0;
      dac_code  <= DAC_RESET;
      dac_write <= 1'b0;
      error_out <= '0;
      locked    <= 1'b0;
      ref_lost  <= 1'b0;
    end else begin
      dac_write <= 1'b0;
      if (!enable) begin
        ticks    <= '0;
        armed    <= 1'b0;
        run      <= '0;
        locked   <= 1'b0;
        ref_lost <= 1'b0;
      end else if (gate_evt) begin
        ticks    <= TW'(1);
        armed    <= 1'b1;
        ref_lost <= 1'b0;
        if (armed && !ref_lost) begin
          dac_code  <= next_code;
          dac_write <= 1'b1;
          error_out <= err;
          if (in_tol) begin
            if (run != '1) run <= run + 1'b1;
            locked <= run_next >= {1'b0, lock_len};
          end else begin
            run    <= '0;
            locked <= 1'b0;
          end
        end
      end else begin
        if (ticks != '1) ticks <= ticks + 1'b1;
        if (lost_now) begin
          ref_lost <= 1'b1;
          armed    <= 1'b0;
          locked   <= 1'b0;
          run      <= '0;
        end
      end
    end
  end
endmodule

module osc_trim_ctrl_chk #(
  parameter int CNT_W = 32,
  parameter int DAC_W = 16
) (
  input logic                    clk_loc,
  input logic                    rst_n,
  input logic                    enable,
  input logic [CNT_W-1:0]        tolerance,
  input logic [DAC_W-1:0]        dac_code,
  input logic                    dac_write,
  input logic signed [CNT_W-1:0] error_out,
  input logic                    locked,
  input logic                    ref_lost
);
  logic [CNT_W-1:0] out_mag;
  assign out_mag = error_out[CNT_W-1] ? $unsigned(-error_out) : $unsigned(error_out);

  a_r6_code_moves_on_write: assert property (@(posedge clk_loc) disable iff (!rst_n)
    !dac_write |-> dac_code == $past(dac_code));

  a_r10_no_write_when_lost: assert property (@(posedge clk_loc) disable iff (!rst_n)
    ref_lost |-> !dac_write);

  a_r9_lost_unlocks: assert property (@(posedge clk_loc) disable iff (!rst_n)
    ref_lost |-> !locked);

  a_r11_idle_when_off: assert property (@(posedge clk_loc) disable iff (!rst_n)
    !enable |=> (!dac_write && !locked && !ref_lost));

  a_r8_out_of_tol_unlocks: assert property (@(posedge clk_loc) disable iff (!rst_n)
    (dac_write && out_mag > $past(tolerance)) |-> !locked);
endmodule

bind osc_trim_ctrl osc_trim_ctrl_chk #(.CNT_W(CNT_W), .DAC_W(DAC_W)) u_chk (
  .clk_loc(clk_loc), .rst_n(rst_n), .enable(enable), .tolerance(tolerance),
  .dac_code(dac_code), .dac_write(dac_write), .error_out(error_out),
  .locked(locked), .ref_lost(ref_lost)
);

// File: tb/sim_osc_trim_ctrl.sv
module sim_osc_trim_ctrl;
  logic clk_ref = 1'b0;
  logic clk_loc = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic ref_run = 1'b1;
  logic [31:0] ref_div = 32'd20;
  logic [31:0] expected = 32'd50;
  logic [4:0]  gain_shift = '0;
  logic [31:0] tolerance = '0;
  logic [7:0]  lock_len = 8'd255;
  logic [15:0] dac_code;
  logic        dac_write;
  logic signed [31:0] error_out;
  logic        locked;
  logic        ref_lost;

  int checks = 0;
  int errors = 0;
  int npulse = 0;
  int last_code = 32768;
  int last_err = 0;
  bit last_lock = 0;
  int wrun = 0;
  int maxw = 0;
  int chg_bad = 0;
  logic [15:0] code_seen = 16'd32768;

  always #2 clk_loc = ~clk_loc;
  always #5 if (ref_run) clk_ref = ~clk_ref;

  osc_trim_ctrl u0 (
    .clk_ref(clk_ref), .clk_loc(clk_loc), .rst_n(rst_n), .enable(enable),
    .ref_div(ref_div), .expected(expected), .gain_shift(gain_shift),
    .tolerance(tolerance), .lock_len(lock_len), .dac_code(dac_code),
    .dac_write(dac_write), .error_out(error_out), .locked(locked), .ref_lost(ref_lost)
  );

  always @(negedge clk_loc) begin
    if (rst_n) begin
      if (dac_write) begin
        npulse++;
        last_code = dac_code;
        last_err = error_out;
        last_lock = locked;
        wrun++;
        if (wrun > maxw) maxw = wrun;
      end else begin
        wrun = 0;
        if (dac_code !== code_seen) chg_bad++;
      end
      code_seen = dac_code;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulses(input int n);
    int target;
    target = npulse + n;
    while (npulse < target) @(negedge clk_loc);
  endtask

  task automatic t_reset;
    chk(dac_code == 16'd32768, "R1 code", dac_code, 32768);
    chk(error_out == 0, "R1 error", error_out, 0);
    chk(!dac_write && !locked && !ref_lost, "R1 flags", {dac_write, locked, ref_lost}, 0);
    repeat (150) @(negedge clk_loc);
    chk(npulse == 0, "R11 no strobe while disabled", npulse, 0);
  endtask

  task automatic t_clamp_low;
    ref_div = 32'd13200; expected = 32'd16600; gain_shift = 0; tolerance = 0; lock_len = 8'd255;
    enable = 1'b1;
    wait_pulses(1);
    chk(last_err == -16400, "R2 long gate error", last_err, -16400);
    chk(last_code == 16368, "R4 step applied", last_code, 16368);
    chk(!ref_lost, "R9 no loss at 2x", ref_lost, 0);
    wait_pulses(1);
    chk(last_code == 0, "R5 clamp at zero", last_code, 0);
  endtask

  task automatic t_basic;
    enable = 1'b0;
    ref_div = 32'd20; expected = 32'd58;
    repeat (7) @(negedge clk_loc);
    enable = 1'b1;
    wait_pulses(1);
    chk(last_err == 8, "R3 partial gate discarded", last_err, 8);
    chk(last_code == 8, "R4 add error", last_code, 8);
    wait_pulses(2);
    chk(last_code == 24, "R2 repeated intervals", last_code, 24);
  endtask

  task automatic t_gain;
    expected = 32'd43; gain_shift = 5'd1;
    wait_pulses(1);
    chk(last_err == -7, "R2 negative error", last_err, -7);
    chk(last_code == 20, "R4 arithmetic shift", last_code, 20);
  endtask

  task automatic t_lock;
    expected = 32'd51; gain_shift = 0; tolerance = 32'd2; lock_len = 8'd3;
    wait_pulses(1);
    chk(!last_lock, "R7 not yet locked 1", last_lock, 0);
    wait_pulses(1);
    chk(!last_lock, "R7 not yet locked 2", last_lock, 0);
    wait_pulses(1);
    chk(last_lock && last_code == 23, "R7 locked after run", {last_lock, last_code[15:0]}, {1'b1, 16'd23});
    expected = 32'd60;
    wait_pulses(1);
    chk(!locked && last_err == 10, "R8 unlock on big error", {locked, last_err[15:0]}, {1'b0, 16'd10});
    chk(last_code == 33, "R4 code after unlock", last_code, 33);
  endtask

  task automatic t_loss;
    int n0;
    int c0;
    expected = 32'd50; lock_len = 8'd1;
    wait_pulses(1);
    chk(last_lock && last_err == 0, "R7 locked before loss", last_lock, 1);
    ref_run = 1'b0;
    repeat (150) @(negedge clk_loc);
    chk(ref_lost, "R9 loss flagged", ref_lost, 1);
    chk(!locked, "R9 lock dropped", locked, 0);
    n0 = npulse; c0 = dac_code;
    repeat (300) @(negedge clk_loc);
    chk(npulse == n0 && dac_code == c0, "R10 frozen", dac_code, c0);
    ref_run = 1'b1;
    while (ref_lost) @(negedge clk_loc);
    @(negedge clk_loc);
    chk(npulse == n0, "R10 first edge discarded", npulse, n0);
    wait_pulses(1);
    chk(last_err == 0 && last_code == 33, "R10 resumes", last_code, 33);
  endtask

  task automatic t_enable;
    int n0;
    enable = 1'b0;
    repeat (2) @(negedge clk_loc);
    chk(!locked && !ref_lost, "R11 flags cleared", {locked, ref_lost}, 0);
    n0 = npulse;
    repeat (200) @(negedge clk_loc);
    chk(npulse == n0 && dac_code == 33, "R11 held while off", dac_code, 33);
    expected = 32'd45;
    repeat (7) @(negedge clk_loc);
    enable = 1'b1;
    wait_pulses(1);
    chk(last_err == -5 && last_code == 28, "R3 discard after enable", last_err, -5);
  endtask

  task automatic t_clamp_high;
    expected = 32'd65550;
    wait_pulses(1);
    chk(last_code == 65528, "R4 large step", last_code, 65528);
    wait_pulses(1);
    chk(last_code == 65535, "R5 clamp at top", last_code, 65535);
    chk(maxw == 1, "R6 strobe width", maxw, 1);
    chk(chg_bad == 0, "R6 code moves only on strobe", chg_bad, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk_loc);
    t_reset_pre: begin
      chk(dac_code == 16'd32768, "R1 code in reset", dac_code, 32768);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk_loc);
    t_reset();
    t_clamp_low();
    t_basic();
    t_gain();
    t_lock();
    t_loss();
    t_enable();
    t_clamp_high();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk_loc);
    checks++;
    errors++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule